// File: doc/BRIEF.md
# Quarter-Wave Microstep Sine/Cosine Generator

This block converts a motor's microstep position into two signed coil amplitudes, one following a sine and one following a cosine. It keeps only one quarter of the waveform period in a small writable table. The remaining three quarters come from mirroring the table index and folding the sign. The second coil's amplitude is the same waveform advanced by a quarter period. Every motor reads the same table, whatever its microstep resolution.

Software or a loader fills the table through a write port. Each write carries two adjacent 6-bit entries. A lookup request supplies an 8-bit step position and a 3-bit resolution shift. Exactly two clocks later the block presents both magnitudes, each with a sign flag. Requests may be issued on every cycle.

Top module: `qwave_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid`, both magnitudes and both sign flags are 0, and every table entry reads as 0.
- R2: A write with `wr_en` high stores `wr_data[5:0]` in entry 2*`wr_addr` and `wr_data[11:6]` in entry 2*`wr_addr`+1. A request accepted in the same cycle as the write, or in any later cycle, already uses the new value.
- R3: When `req_valid` is high at a rising edge, `out_valid` is high for exactly one cycle, after the second rising edge that follows. Requests on consecutive cycles produce results on consecutive cycles, in the same order.
- R4: The lookup phase is `(req_pos << req_res)` truncated to 8 bits. With phase bits [7:6] equal to 00, `sin_mag` is entry phase[5:0] and `sin_neg` is 0.
- R5: With phase bits [7:6] equal to 01, `sin_mag` is entry 63 - phase[5:0] and `sin_neg` is 0.
- R6: With phase bits [7:6] equal to 10 or 11, `sin_mag` uses the same entry as for 00 or 01 respectively, and `sin_neg` is 1, even when the magnitude is 0.
- R7: `cos_mag` and `cos_neg` equal the sine result for phase + 64 modulo 256.
- R8: For every `req_res` value from 0 to 7, the resolution shift applies before quadrant selection, so coarser settings skip table entries.
- R9: With `wr_en` low, no table entry changes, whatever `wr_addr` and `wr_data` hold.
- R10: In cycles where `out_valid` is low, the magnitudes and sign flags keep the values of the most recent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 5 | Entry-pair address |
| wr_data | input | 12 | Even entry in [5:0], odd entry in [11:6] |
| req_valid | input | 1 | Lookup request strobe |
| req_pos | input | 8 | Motor microstep position |
| req_res | input | 3 | Left shift applied to the position |
| out_valid | output | 1 | Result strobe, two clocks after the request |
| sin_mag | output | 6 | Sine magnitude |
| sin_neg | output | 1 | Sine sign, 1 means negative |
| cos_mag | output | 6 | Cosine magnitude |
| cos_neg | output | 1 | Cosine sign, 1 means negative |

## Verification
The table is loaded with a permutation, so every entry holds a different value. A wrong mirror, a wrong quadrant or an off-by-one index therefore shows up as a wrong magnitude on the very result of the affected request, two clocks after it is issued. A corrupted table word, or a write landing in the wrong half of a pair, appears on the first lookup that reaches that entry. A pipeline valid or a held register that slips by a cycle appears at once as a missing or doubled `out_valid` pulse, or as an output that changes while idle.

// File: rtl/qwave_pkg.sv
package qwave_pkg;
    parameter int PH_W  = 8;
    parameter int AMP_W = 6;
    parameter int RES_W = 3;
    localparam int IDX_W   = PH_W - 2;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int ADDR_W  = IDX_W - 1;
    localparam int QTR     = 1 << IDX_W;

    typedef struct packed {
        logic            valid;
        logic [PH_W-1:0] phase;
    } req_stage_t;

    typedef struct packed {
        logic             valid;
        logic [AMP_W-1:0] sin_mag;
        logic             sin_neg;
        logic [AMP_W-1:0] cos_mag;
        logic             cos_neg;
    } out_stage_t;
endpackage

// File: rtl/qwave_fold.sv
module qwave_fold #(
    parameter int PH_W = qwave_pkg::PH_W,
    localparam int IDX_W = PH_W - 2
) (
    input  logic [PH_W-1:0]  phase,
    output logic [IDX_W-1:0] idx,
    output logic             neg
);
    logic [1:0]       quad;
    logic [IDX_W-1:0] low;

    always_comb begin
        quad = phase[PH_W-1:PH_W-2];
        low  = phase[IDX_W-1:0];
        idx  = quad[0] ? ~low : low;
        neg  = quad[1];
    end
endmodule

// File: rtl/qwave_table.sv
module qwave_table
    import qwave_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [2*AMP_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx_a,
    input  logic [IDX_W-1:0]   rd_idx_b,
    output logic [AMP_W-1:0]   rd_a,
    output logic [AMP_W-1:0]   rd_b
);
    logic [ENTRIES-1:0][AMP_W-1:0] ent_d, ent_q;
    logic [IDX_W-1:0] lo_idx, hi_idx;

    always_comb begin
        lo_idx = {wr_addr, 1'b0};
        hi_idx = {wr_addr, 1'b1};
        ent_d  = ent_q;
        if (wr_en) begin
            ent_d[lo_idx] = wr_data[AMP_W-1:0];
            ent_d[hi_idx] = wr_data[2*AMP_W-1:AMP_W];
        end
        rd_a = ent_q[rd_idx_a];
        rd_b = ent_q[rd_idx_b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assert_write_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_q[$past(lo_idx)] == $past(wr_data[AMP_W-1:0])));
    assert_write_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_q[$past(hi_idx)] == $past(wr_data[2*AMP_W-1:AMP_W])));
    assert_no_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ent_q));
endmodule

// File: rtl/qwave_gen.sv
module qwave_gen
    import qwave_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [2*AMP_W-1:0] wr_data,
    input  logic               req_valid,
    input  logic [PH_W-1:0]    req_pos,
    input  logic [RES_W-1:0]   req_res,
    output logic               out_valid,
    output logic [AMP_W-1:0]   sin_mag,
    output logic               sin_neg,
    output logic [AMP_W-1:0]   cos_mag,
    output logic               cos_neg
);
    req_stage_t s1_d, s1_q;
    out_stage_t o_d,  o_q;

    logic [1:0][PH_W-1:0]  ph;
    logic [1:0][IDX_W-1:0] idx;
    logic [1:0]            neg;
    logic [AMP_W-1:0]      amp_sin, amp_cos;

    // Index 0 folds the sine phase, index 1 the quarter-advanced cosine phase.
    for (genvar g = 0; g < 2; g++) begin : g_fold
        assign ph[g] = s1_q.phase + PH_W'(g * QTR);
        qwave_fold #(.PH_W(PH_W)) fold_i (
            .phase (ph[g]),
            .idx   (idx[g]),
            .neg   (neg[g])
        );
    end

    qwave_table table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_idx_a (idx[0]),
        .rd_idx_b (idx[1]),
        .rd_a     (amp_sin),
        .rd_b     (amp_cos)
    );

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = req_valid;
        if (req_valid) s1_d.phase = req_pos << req_res;

        o_d       = o_q;
        o_d.valid = s1_q.valid;
        if (s1_q.valid) begin
            o_d.sin_mag = amp_sin;
            o_d.sin_neg = neg[0];
            o_d.cos_mag = amp_cos;
            o_d.cos_neg = neg[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            o_q  <= '0;
        end else begin
            s1_q <= s1_d;
            o_q  <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign sin_mag   = o_q.sin_mag;
    assign sin_neg   = o_q.sin_neg;
    assign cos_mag   = o_q.cos_mag;
    assign cos_neg   = o_q.cos_neg;

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid, 2));
    assert_cos_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cos_neg == (sin_neg ^ $past(s1_q.phase[PH_W-2]))));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(sin_mag) && $stable(cos_mag) && $stable(sin_neg) && $stable(cos_neg)));
endmodule

// File: tb/qwave_gen_tb.sv
`timescale 1ns/1ps
module qwave_gen_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [4:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        req_valid = 0;
    logic [7:0]  req_pos = '0;
    logic [2:0]  req_res = '0;
    logic        out_valid, sin_neg, cos_neg;
    logic [5:0]  sin_mag, cos_mag;

    int n_chk = 0, n_fail = 0;
    int tbl [64];
    bit done = 0;

    always #2 clk = ~clk;

    qwave_gen dut_i (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model(input int ph, output int mag, output int ng);
        int q, low, ix;
        q = (ph >> 6) & 3;
        low = ph & 63;
        ix = (q & 1) ? 63 - low : low;
        mag = tbl[ix];
        ng = q >> 1;
    endfunction

    // One lookup; result sampled two edges later, then checks single pulse.
    task automatic lookup(input int pos, input int res, input string tag);
        int ph, sm, sn, cm, cn;
        ph = (pos << res) & 255;
        model(ph, sm, sn);
        model((ph + 64) & 255, cm, cn);
        @(negedge clk);
        req_valid = 1; req_pos = 8'(pos); req_res = 3'(res);
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk({tag, " valid"}, out_valid, 1);
        chk({tag, " sin_mag"}, sin_mag, sm);
        chk({tag, " sin_neg"}, sin_neg, sn);
        chk({tag, " cos_mag R7"}, cos_mag, cm);
        chk({tag, " cos_neg R7"}, cos_neg, cn);
        @(negedge clk);
        chk({tag, " pulse R3"}, out_valid, 0);
    endtask

    task automatic write_pair(input int a, input int e, input int o);
        @(negedge clk);
        wr_en = 1; wr_addr = 5'(a); wr_data = {6'(o), 6'(e)};
        tbl[2*a] = e; tbl[2*a+1] = o;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 valid", out_valid, 0);
        chk("R1 sin", sin_mag, 0);
        chk("R1 cos", cos_mag, 0);
        chk("R1 signs", {sin_neg, cos_neg}, 0);
        rst_n = 1;
        for (int i = 0; i < 64; i++) tbl[i] = 0;
        lookup(0, 0, "R1 table zero");
    endtask

    task automatic t_load();
        for (int a = 0; a < 32; a++)
            write_pair(a, (2*a*5 + 3) % 64, ((2*a+1)*5 + 3) % 64);
        lookup(10, 0, "R2 even entry");
        lookup(11, 0, "R2 odd entry");
    endtask

    task automatic t_quadrants();
        for (int p = 0; p < 256; p++) begin
            if (p < 64)       lookup(p, 0, "R4 q0");
            else if (p < 128) lookup(p, 0, "R5 q1");
            else              lookup(p, 0, "R6 q2q3");
        end
    endtask

    task automatic t_res();
        for (int r = 0; r < 8; r++) begin
            lookup(37, r, "R8 shift");
            lookup(201, r, "R8 shift");
        end
    endtask

    task automatic t_zero_neg();
        write_pair(0, 0, tbl[1]);
        lookup(128, 0, "R6 zero mag neg");
    endtask

    task automatic t_same_cycle_write();
        int sm, sn;
        @(negedge clk);
        wr_en = 1; wr_addr = 5'd2; wr_data = {6'(tbl[5]), 6'd42};
        req_valid = 1; req_pos = 8'd4; req_res = 3'd0;
        tbl[4] = 42;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        @(negedge clk);
        model(4, sm, sn);
        chk("R2 same-cycle write", sin_mag, sm);
    endtask

    task automatic t_no_write();
        @(negedge clk);
        wr_en = 0; wr_addr = 5'd3; wr_data = 12'hFFF;
        repeat (2) @(negedge clk);
        lookup(6, 0, "R9 no write even");
        lookup(7, 0, "R9 no write odd");
    endtask

    task automatic t_back_to_back();
        int sm [4], sn [4], cm, cn;
        for (int i = 0; i < 4; i++) model((i * 50 + 20) & 255, sm[i], sn[i]);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            req_valid = 1; req_pos = 8'(i * 50 + 20); req_res = 0;
            @(negedge clk);
            if (i >= 1) begin
                chk("R3 b2b valid", out_valid, 1);
                chk("R3 b2b order", sin_mag, sm[i-1]);
            end
        end
        req_valid = 0;
        @(negedge clk);
        chk("R3 b2b last", sin_mag, sm[3]);
        chk("R3 b2b sign", sin_neg, sn[3]);
        model((3 * 50 + 20 + 64) & 255, cm, cn);
        repeat (3) @(negedge clk);
        chk("R10 idle valid", out_valid, 0);
        chk("R10 hold sin", sin_mag, sm[3]);
        chk("R10 hold cos", cos_mag, cm);
        chk("R10 hold sign", cos_neg, cn);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_quadrants();
        t_res();
        t_zero_neg();
        t_same_cycle_write();
        t_no_write();
        t_back_to_back();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule